// File: doc/BRIEF.md
# Quadrature Position Counter with Coherent Byte Reads

This block follows the motion of an incremental encoder. Two quadrature channels are synchronised, decoded at four counts per cycle, and accumulated in a 16-bit up/down position counter. On each rising clock edge the counter is copied into a holding register, and a host reads that register one byte at a time over an 8-bit bus. Two host inputs control the bus: a byte selector and an active-low bus enable.

A host that needs the full 16-bit value reads the upper byte first and then the lower byte. Freeze logic samples the host inputs on the falling clock edge. It stops copies into the holding register from the moment an upper-byte read is seen until the read has completed. Both bytes therefore come from the same count, and the counter keeps tracking motion underneath.

A host that needs only 8 bits keeps the selector high. The freeze never engages in that case, and the holding register refreshes every cycle. The bus is modelled as a data value plus a drive flag.

Top module: `qenc_pos_reader`

## Requirements
- R1: Channel inputs are decoded at four counts per cycle. Write the channel pair as {A,B}. The forward sequence 00→10→11→01→00 adds one per step, and the reverse sequence subtracts one per step.
- R2: A change of both channels between two consecutive synchronised samples is illegal and leaves the count unchanged.
- R3: The count wraps modulo 65536 in both directions, so 0xFFFF+1 gives 0x0000 and 0x0000−1 gives 0xFFFF.
- R4: While the freeze is off, the holding register loads the count on every rising edge. A channel change reaches the holding register four rising edges after it is applied: two synchroniser stages, the count update, and the load.
- R5: With `bus_en_n` low, `drive_en` is 1 and `data_out` carries bits 15:8 of the holding register when `lo_sel` is 0, or bits 7:0 when `lo_sel` is 1. With `bus_en_n` high, `drive_en` is 0 and `data_out` is 0.
- R6: A falling edge that samples `bus_en_n`=0 with `lo_sel`=0 turns the freeze on. After that, an upper-then-lower read returns both bytes of one count, even if the counter moves during the read.
- R7: The freeze turns off only when two conditions are seen in order. First, a falling edge samples `lo_sel`=1 with `bus_en_n`=0. Second, a later falling edge samples `bus_en_n`=1. Raising `bus_en_n` before the first condition leaves the freeze on.
- R8: With `lo_sel` held at 1, the freeze never engages and the holding register tracks the count even while `bus_en_n` stays low.
- R9: Reset (`rst_n` low) clears the counter, the holding register, the freeze and the first-condition flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counter and holding register on rising edge, host sampling on falling edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| quad_a | input | 1 | Quadrature channel A, asynchronous |
| quad_b | input | 1 | Quadrature channel B, asynchronous |
| bus_en_n | input | 1 | Active-low bus enable from the host |
| lo_sel | input | 1 | Byte selector: 0 upper byte, 1 lower byte |
| data_out | output | 8 | Selected byte of the holding register |
| drive_en | output | 1 | High when the bus is driven |

## Verification
The embedded properties check these rules on every cycle:
- The count moves by at most one per cycle.
- An illegal double transition freezes the count.
- The holding register stays still while frozen and copies the count while not frozen.
- An upper-byte sample engages the freeze.
- Raising the enable alone does not release the freeze.
- A held-high selector keeps the freeze off.

Some behaviour can only be shown by the bench scenarios:
- That the two bytes of a read belong to one count while the counter moves underneath.
- The exact Gray-code direction and the wrap values.
- The four-edge latency.
- That reset clears a freeze left in progress.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_SKIP = 2'd3
  } qstep_e;

  // prev/cur are {A,B}. Forward order 00->10->11->01->00.
  function automatic qstep_e decode_step(input logic [1:0] prev, input logic [1:0] cur);
    logic a_chg;
    logic b_chg;
    a_chg = prev[1] ^ cur[1];
    b_chg = prev[0] ^ cur[0];
    if (a_chg && b_chg) begin
      decode_step = STEP_SKIP;
    end else if (!a_chg && !b_chg) begin
      decode_step = STEP_HOLD;
    end else if (cur[1] ^ prev[0]) begin
      decode_step = STEP_INC;
    end else begin
      decode_step = STEP_DEC;
    end
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ab_i,
  output logic [CNT_W-1:0] count_o
);

  logic [1:0]       prev_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  qstep_e           step;

  always_comb begin
    step     = decode_step(prev_q, ab_i);
    count_en = (step == STEP_INC) || (step == STEP_DEC);
    count_d  = count_q;
    if (step == STEP_INC) begin
      count_d = count_q + CNT_W'(1);
    end else if (step == STEP_DEC) begin
      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= ab_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  assert_unit_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q)) ||
             (count_q == CNT_W'($past(count_q) + CNT_W'(1))) ||
             (count_q == CNT_W'($past(count_q) - CNT_W'(1))));

  assert_skip_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_SKIP) |=> $stable(count_q));

endmodule

// File: rtl/qenc_read_guard.sv
module qenc_read_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en_n,
  input  logic lo_sel,
  output logic freeze_o
);

  logic freeze_q, freeze_d;
  logic lo_seen_q, lo_seen_d;

  always_comb begin
    freeze_d  = freeze_q;
    lo_seen_d = lo_seen_q;
    if (!freeze_q) begin
      if (!bus_en_n && !lo_sel) begin
        freeze_d  = 1'b1;
        lo_seen_d = 1'b0;
      end
    end else begin
      if (!bus_en_n && lo_sel) begin
        lo_seen_d = 1'b1;
      end
      if (bus_en_n && lo_seen_q) begin
        freeze_d  = 1'b0;
        lo_seen_d = 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q  <= 1'b0;
      lo_seen_q <= 1'b0;
    end else begin
      freeze_q  <= freeze_d;
      lo_seen_q <= lo_seen_d;
    end
  end

  assign freeze_o = freeze_q;

  assert_hi_read_freezes_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (!freeze_q && !bus_en_n && !lo_sel) |=> freeze_q);

  assert_release_order_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (freeze_q && !lo_seen_q && bus_en_n) |=> freeze_q);

  assert_lo_only_open_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (!freeze_q && lo_sel) |=> !freeze_q);

endmodule

// File: rtl/qenc_pos_reader.sv
module qenc_pos_reader #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             bus_en_n,
  input  logic             lo_sel,
  output logic [BUS_W-1:0] data_out,
  output logic             drive_en
);

  localparam int CNT_W = 2 * BUS_W;

  logic [1:0]       ab_sync;
  logic [CNT_W-1:0] count;
  logic             freeze;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             hold_en;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({quad_a, quad_b}),
    .sync_o  (ab_sync)
  );

  qenc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .ab_i    (ab_sync),
    .count_o (count)
  );

  qenc_read_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en_n (bus_en_n),
    .lo_sel   (lo_sel),
    .freeze_o (freeze)
  );

  always_comb begin
    hold_en = !freeze;
    hold_d  = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_comb begin
    drive_en = !bus_en_n;
    data_out = '0;
    if (!bus_en_n) begin
      data_out = lo_sel ? hold_q[BUS_W-1:0] : hold_q[CNT_W-1:BUS_W];
    end
  end

  assert_frozen_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(hold_q));

  assert_open_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (hold_q == $past(count)));

endmodule

// File: tb/qenc_pos_reader_tb.sv
module qenc_pos_reader_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, quad_a, quad_b, bus_en_n, lo_sel;
  logic [7:0] data_out;
  logic       drive_en;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  int          ph    = 0;
  logic [15:0] exp_cnt = 16'h0000;
  logic [15:0] got;

  // {A,B, expected count after the move}
  localparam logic [17:0] VEC [14] = '{
    {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
    {2'b01, 16'h0003}, {2'b11, 16'h0002}, {2'b10, 16'h0001}, {2'b00, 16'h0000},
    {2'b01, 16'hFFFF}, {2'b11, 16'hFFFE}, {2'b00, 16'hFFFE}, {2'b11, 16'hFFFE},
    {2'b01, 16'hFFFF}, {2'b00, 16'h0000}
  };

  qenc_pos_reader u_dut (
    .clk(clk), .rst_n(rst_n), .quad_a(quad_a), .quad_b(quad_b),
    .bus_en_n(bus_en_n), .lo_sel(lo_sel), .data_out(data_out), .drive_en(drive_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] phase_ab(input int p);
    case (p & 3)
      0:       return 2'b00;
      1:       return 2'b10;
      2:       return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic step(input int dir);
    ph = ph + dir;
    {quad_a, quad_b} = phase_ab(ph);
    exp_cnt = exp_cnt + 16'(dir);
  endtask

  task automatic read_word(output logic [15:0] v);
    bus_en_n = 1'b0; lo_sel = 1'b0;
    tick(1);
    v[15:8] = data_out;
    lo_sel = 1'b1;
    tick(1);
    v[7:0] = data_out;
    bus_en_n = 1'b1;
    tick(1);
  endtask

  initial begin
    rst_n = 1'b0; quad_a = 1'b0; quad_b = 1'b0; bus_en_n = 1'b1; lo_sel = 1'b0;
    tick(3);
    chk("R5 idle drive_en", {15'd0, drive_en}, 16'd0);
    chk("R5 idle data", {8'd0, data_out}, 16'd0);
    rst_n = 1'b1;
    tick(2);
    read_word(got);
    chk("R9 reset value", got, 16'h0000);

    // R1 R2 R3 R4: vector table walk
    for (int i = 0; i < 14; i++) begin
      {quad_a, quad_b} = VEC[i][17:16];
      tick(6);
      read_word(got);
      chk($sformatf("R1 R2 R3 R4 vector %0d", i), got, VEC[i][15:0]);
    end
    ph = 0; exp_cnt = 16'h0000;

    // R4: four-edge latency
    step(1);
    tick(3);
    bus_en_n = 1'b0; lo_sel = 1'b1;
    #0;
    chk("R4 not yet at 3 edges", {8'd0, data_out}, 16'h0000);
    tick(1);
    chk("R4 visible at 4 edges", {8'd0, data_out}, 16'h0001);
    bus_en_n = 1'b1;
    tick(2);
    step(-1);
    tick(6);

    // R5 R6: coherent read across a move, 0xFFFF -> 0x0000
    step(-1);
    tick(6);
    bus_en_n = 1'b0; lo_sel = 1'b0;
    tick(1);
    chk("R5 drive_en during read", {15'd0, drive_en}, 16'd1);
    chk("R6 high byte", {8'd0, data_out}, 16'h00FF);
    step(1);
    tick(6);
    lo_sel = 1'b1;
    tick(1);
    chk("R6 low byte coherent", {8'd0, data_out}, 16'h00FF);
    bus_en_n = 1'b1;
    tick(2);
    chk("R5 released bus", {15'd0, drive_en}, 16'd0);
    read_word(got);
    chk("R6 new value after release", got, exp_cnt);

    // R7: enable raised before the low byte keeps the freeze
    bus_en_n = 1'b0; lo_sel = 1'b0;
    tick(1);
    bus_en_n = 1'b1;
    tick(1);
    step(1);
    tick(6);
    bus_en_n = 1'b0; lo_sel = 1'b1;
    tick(1);
    chk("R7 still frozen", {8'd0, data_out}, 16'h0000);
    bus_en_n = 1'b1;
    tick(2);
    read_word(got);
    chk("R7 released after order", got, 16'h0001);

    // R8: selector held high, bus enabled throughout
    bus_en_n = 1'b0; lo_sel = 1'b1;
    step(1);
    tick(6);
    chk("R8 tracks step 1", {8'd0, data_out}, 16'h0002);
    step(1);
    tick(6);
    chk("R8 tracks step 2", {8'd0, data_out}, 16'h0003);
    bus_en_n = 1'b1;
    tick(1);

    // R9: reset during a freeze
    bus_en_n = 1'b0; lo_sel = 1'b0;
    tick(1);
    rst_n = 1'b0; bus_en_n = 1'b1; quad_a = 1'b0; quad_b = 1'b0;
    ph = 0; exp_cnt = 16'h0000;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    step(1);
    tick(6);
    bus_en_n = 1'b0; lo_sel = 1'b1;
    tick(1);
    chk("R9 freeze cleared by reset", {8'd0, data_out}, 16'h0001);
    bus_en_n = 1'b1;
    tick(1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule